// File: doc/BRIEF.md
# Level-wise micro-operation sequencer

This controller walks a decision-diagram netlist that has been sorted into dependency levels, one level after another. It drives a bank of identical compute slices in lockstep. Every active slice receives the same micro-operation code in the same cycle, and each slice holds one multiplexer node of the current level. A small group of inverter lanes runs alongside the slices. Before a run, software loads a per-level descriptor table through a write port. Each entry gives the number of multiplexer nodes and the number of inverter nodes in that level.

A start pulse launches a run over the first `level_count` table entries. The number of cycles a level takes depends on what it holds. A level with at least one multiplexer runs the full eight-step sequence. A level with only inverters runs a three-step sequence. A level with neither holds only constant-1 nodes, which are written straight into the data region, so it takes no cycles and is skipped. Buffer write strobes carry the current level index, and the strobe bit position is the node index, so later levels can fetch the results.

Top module: `lvl_uop_sequencer`

## Requirements
- R1: After reset, `uop` is 0 (idle), all four masks are zero, `busy`, `done` and `cycle_count` are 0.
- R2: A level whose multiplexer count is nonzero issues codes 1 to 8 on consecutive cycles: 1 preset all cells, 2 write data inputs, 3 write select and its complement, 4 evaluate both first-stage NORs, 5 evaluate the second-stage NOR, 6 evaluate the final NOT, 7 read the output, 8 store to buffer.
- R3: A level with zero multiplexers and a nonzero inverter count issues codes 9 (preset inverter lanes), 10 (load inputs) and 11 (evaluate) on three consecutive cycles.
- R4: During all eight steps of a multiplexer level, `slice_en` bit i is 1 exactly when i is less than the level's multiplexer count, saturating at all ones. In any other cycle `slice_en` is zero.
- R5: In a multiplexer level, `inv_en` bit i is 1 only in the code-3 cycle and only for i below the inverter count. In an inverter-only level, that same mask is driven in all three cycles.
- R6: `buf_we` equals the `slice_en` mask in the code-8 cycle and is zero otherwise. `buf_inv_we` carries the inverter mask in the code-8 cycle of a multiplexer level, or in the code-11 cycle of an inverter-only level. `buf_level` gives the level index of the step in progress.
- R7: Levels run in ascending index order with no idle cycle between them. Entries whose counts are both zero, and entries at or beyond `level_count`, issue no cycles.
- R8: `done` rises in the cycle after the last step of the last non-empty level. With no non-empty level, it rises in the cycle after start is accepted. It then holds until the next accepted start. `busy` is 1 exactly in cycles where a nonzero code is issued.
- R9: `cycle_count` clears when start is accepted and rises by one after each issued step. When `done` is set, it equals 8 times the multiplexer levels plus 3 times the inverter-only levels.
- R10: A start pulse while `busy` is 1 has no effect on the running sequence, the masks, the level order or `cycle_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Descriptor table write enable |
| tbl_level | input | LVL_W | Table entry to write |
| tbl_mux_cnt | input | MCNT_W | Multiplexer nodes in that level |
| tbl_inv_cnt | input | ICNT_W | Inverter nodes in that level |
| level_count | input | LVL_W+1 | Number of table entries to run, sampled at start |
| start | input | 1 | Launch a run (ignored while busy) |
| uop | output | 4 | Micro-operation code broadcast to slices |
| slice_en | output | NUM_SLICES | Multiplexer slice enable mask |
| inv_en | output | NUM_INV | Inverter lane enable mask |
| buf_we | output | NUM_SLICES | Buffer write strobes from slices, bit = node index |
| buf_inv_we | output | NUM_INV | Buffer write strobes from inverter lanes |
| buf_level | output | LVL_W | Level index for the current step and buffer write |
| busy | output | 1 | A step is being issued |
| done | output | 1 | Run complete |
| cycle_count | output | CNT_W | Steps issued since the last accepted start |

## Verification
Two things can happen in the same cycle. The store step of one level can be followed directly by the preset of the next level, and a new start pulse can arrive during a step. The bench provokes both. It runs tables where a multiplexer level is followed straight away by an inverter-only level, with empty entries in between, and it pulses start partway through such a run. A per-cycle expected stream built from the table must match every output, with no bubble and no restart, and `cycle_count` must keep climbing through the stray pulse.

// File: rtl/lvl_seq_pkg.sv
package lvl_seq_pkg;

   typedef enum logic [3:0] {
      UOP_IDLE       = 4'd0,
      UOP_PRESET     = 4'd1,
      UOP_WR_DATA    = 4'd2,
      UOP_WR_SEL     = 4'd3,
      UOP_NOR_A      = 4'd4,
      UOP_NOR_B      = 4'd5,
      UOP_NOT        = 4'd6,
      UOP_READ       = 4'd7,
      UOP_STORE      = 4'd8,
      UOP_INV_PRESET = 4'd9,
      UOP_INV_LOAD   = 4'd10,
      UOP_INV_EVAL   = 4'd11
   } uop_e;

   localparam int MUX_STEPS = 8;
   localparam int INV_STEPS = 3;

endpackage

// File: rtl/lvl_desc_table.sv
module lvl_desc_table #(
   parameter int MAX_LEVELS = 8,
   parameter int LVL_W      = 3,
   parameter int MCNT_W     = 3,
   parameter int ICNT_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [LVL_W-1:0]  wr_level,
   input  logic [MCNT_W-1:0] wr_mux,
   input  logic [ICNT_W-1:0] wr_inv,
   input  logic [LVL_W-1:0]  rd_level,
   output logic [MCNT_W-1:0] rd_mux,
   output logic [ICNT_W-1:0] rd_inv,
   input  logic [LVL_W:0]    lim,
   output logic [MAX_LEVELS-1:0] live
);

   logic [MCNT_W-1:0] mux_flat [MAX_LEVELS];
   logic [ICNT_W-1:0] inv_flat [MAX_LEVELS];

   for (genvar e = 0; e < MAX_LEVELS; e++) begin : g_ent
      logic [MCNT_W-1:0] mux_q;
      logic [ICNT_W-1:0] inv_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mux_q <= '0;
            inv_q <= '0;
         end else if (wr_en && (wr_level == LVL_W'(e))) begin
            mux_q <= wr_mux;
            inv_q <= wr_inv;
         end
      end

      assign mux_flat[e] = mux_q;
      assign inv_flat[e] = inv_q;
      assign live[e] = ((mux_q != '0) || (inv_q != '0)) &&
                       ((LVL_W+1)'(e) < lim);
   end

   assign rd_mux = mux_flat[rd_level];
   assign rd_inv = inv_flat[rd_level];

endmodule

// File: rtl/lvl_next_find.sv
module lvl_next_find #(
   parameter int MAX_LEVELS = 8,
   parameter int LVL_W      = 3
) (
   input  logic [MAX_LEVELS-1:0] live,
   input  logic [LVL_W:0]        from,
   output logic                  found,
   output logic [LVL_W-1:0]      idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = MAX_LEVELS - 1; i >= 0; i--) begin
         if (live[i] && ((LVL_W+1)'(i) >= from)) begin
            found = 1'b1;
            idx   = LVL_W'(i);
         end
      end
   end

endmodule

// File: rtl/lvl_step_decode.sv
module lvl_step_decode
   import lvl_seq_pkg::*;
#(
   parameter int NUM_SLICES = 4,
   parameter int NUM_INV    = 4,
   parameter int MCNT_W     = 3,
   parameter int ICNT_W     = 3
) (
   input  logic                  active,
   input  logic [2:0]            step,
   input  logic [MCNT_W-1:0]     mux_cnt,
   input  logic [ICNT_W-1:0]     inv_cnt,
   output uop_e                  uop,
   output logic [NUM_SLICES-1:0] slice_en,
   output logic [NUM_INV-1:0]    inv_en,
   output logic [NUM_SLICES-1:0] buf_we,
   output logic [NUM_INV-1:0]    buf_inv_we,
   output logic                  step_last
);

   logic [NUM_SLICES-1:0] m_th;
   logic [NUM_INV-1:0]    i_th;
   logic                  is_mux;

   for (genvar s = 0; s < NUM_SLICES; s++) begin : g_mth
      assign m_th[s] = (mux_cnt > MCNT_W'(s));
   end
   for (genvar v = 0; v < NUM_INV; v++) begin : g_ith
      assign i_th[v] = (inv_cnt > ICNT_W'(v));
   end

   assign is_mux    = (mux_cnt != '0);
   assign step_last = is_mux ? (step == 3'(MUX_STEPS - 1))
                             : (step == 3'(INV_STEPS - 1));

   always_comb begin
      uop        = UOP_IDLE;
      slice_en   = '0;
      inv_en     = '0;
      buf_we     = '0;
      buf_inv_we = '0;
      if (active) begin
         if (is_mux) begin
            slice_en = m_th;
            case (step)
               3'd0: uop = UOP_PRESET;
               3'd1: uop = UOP_WR_DATA;
               3'd2: begin
                  uop    = UOP_WR_SEL;
                  inv_en = i_th;
               end
               3'd3: uop = UOP_NOR_A;
               3'd4: uop = UOP_NOR_B;
               3'd5: uop = UOP_NOT;
               3'd6: uop = UOP_READ;
               default: begin
                  uop        = UOP_STORE;
                  buf_we     = m_th;
                  buf_inv_we = i_th;
               end
            endcase
         end else begin
            inv_en = i_th;
            case (step)
               3'd0:    uop = UOP_INV_PRESET;
               3'd1:    uop = UOP_INV_LOAD;
               default: begin
                  uop        = UOP_INV_EVAL;
                  buf_inv_we = i_th;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/lvl_uop_sequencer.sv
module lvl_uop_sequencer
   import lvl_seq_pkg::*;
#(
   parameter int NUM_SLICES = 4,
   parameter int NUM_INV    = 4,
   parameter int MAX_LEVELS = 8,
   parameter int CNT_W      = 16,
   localparam int LVL_W     = (MAX_LEVELS > 1) ? $clog2(MAX_LEVELS) : 1,
   localparam int MCNT_W    = $clog2(NUM_SLICES + 1),
   localparam int ICNT_W    = $clog2(NUM_INV + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tbl_we,
   input  logic [LVL_W-1:0]      tbl_level,
   input  logic [MCNT_W-1:0]     tbl_mux_cnt,
   input  logic [ICNT_W-1:0]     tbl_inv_cnt,
   input  logic [LVL_W:0]        level_count,
   input  logic                  start,
   output logic [3:0]            uop,
   output logic [NUM_SLICES-1:0] slice_en,
   output logic [NUM_INV-1:0]    inv_en,
   output logic [NUM_SLICES-1:0] buf_we,
   output logic [NUM_INV-1:0]    buf_inv_we,
   output logic [LVL_W-1:0]      buf_level,
   output logic                  busy,
   output logic                  done,
   output logic [CNT_W-1:0]      cycle_count
);

   if (NUM_SLICES < 1) begin : g_bad_slices
      $error("NUM_SLICES must be at least 1");
   end
   if (NUM_INV < 1) begin : g_bad_inv
      $error("NUM_INV must be at least 1");
   end
   if (MAX_LEVELS < 2) begin : g_bad_levels
      $error("MAX_LEVELS must be at least 2");
   end
   if (CNT_W < 4) begin : g_bad_cnt
      $error("CNT_W must be at least 4");
   end

   logic [LVL_W-1:0]      cur_q;
   logic [2:0]            step_q;
   logic [LVL_W:0]        lim_q;
   logic                  busy_q;
   logic                  done_q;
   logic [CNT_W-1:0]      cnt_q;

   logic [MCNT_W-1:0]     cur_mux;
   logic [ICNT_W-1:0]     cur_inv;
   logic [MAX_LEVELS-1:0] live;
   logic [LVL_W:0]        find_from;
   logic [LVL_W:0]        find_lim;
   logic                  nxt_found;
   logic [LVL_W-1:0]      nxt_idx;
   logic                  step_last;
   uop_e                  uop_w;

   assign find_lim  = busy_q ? lim_q : level_count;
   assign find_from = busy_q ? ({1'b0, cur_q} + 1'b1) : '0;

   lvl_desc_table #(
      .MAX_LEVELS (MAX_LEVELS),
      .LVL_W      (LVL_W),
      .MCNT_W     (MCNT_W),
      .ICNT_W     (ICNT_W)
   ) table_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_we),
      .wr_level (tbl_level),
      .wr_mux   (tbl_mux_cnt),
      .wr_inv   (tbl_inv_cnt),
      .rd_level (cur_q),
      .rd_mux   (cur_mux),
      .rd_inv   (cur_inv),
      .lim      (find_lim),
      .live     (live)
   );

   lvl_next_find #(
      .MAX_LEVELS (MAX_LEVELS),
      .LVL_W      (LVL_W)
   ) find_i (
      .live  (live),
      .from  (find_from),
      .found (nxt_found),
      .idx   (nxt_idx)
   );

   lvl_step_decode #(
      .NUM_SLICES (NUM_SLICES),
      .NUM_INV    (NUM_INV),
      .MCNT_W     (MCNT_W),
      .ICNT_W     (ICNT_W)
   ) dec_i (
      .active     (busy_q),
      .step       (step_q),
      .mux_cnt    (cur_mux),
      .inv_cnt    (cur_inv),
      .uop        (uop_w),
      .slice_en   (slice_en),
      .inv_en     (inv_en),
      .buf_we     (buf_we),
      .buf_inv_we (buf_inv_we),
      .step_last  (step_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         step_q <= '0;
         lim_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (start) begin
            lim_q  <= level_count;
            cnt_q  <= '0;
            step_q <= '0;
            if (nxt_found) begin
               busy_q <= 1'b1;
               done_q <= 1'b0;
               cur_q  <= nxt_idx;
            end else begin
               done_q <= 1'b1;
            end
         end
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (step_last) begin
            step_q <= '0;
            if (nxt_found) begin
               cur_q <= nxt_idx;
            end else begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end else begin
            step_q <= step_q + 3'd1;
         end
      end
   end

   assign uop         = uop_w;
   assign buf_level   = cur_q;
   assign busy        = busy_q;
   assign done        = done_q;
   assign cycle_count = cnt_q;

endmodule

// File: rtl/lvl_seq_chk.sv
module lvl_seq_chk #(
   parameter int NUM_SLICES = 4,
   parameter int NUM_INV    = 4,
   parameter int LVL_W      = 3,
   parameter int CNT_W      = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start,
   input logic [3:0]            uop,
   input logic [NUM_SLICES-1:0] slice_en,
   input logic [NUM_INV-1:0]    inv_en,
   input logic [NUM_SLICES-1:0] buf_we,
   input logic [LVL_W-1:0]      buf_level,
   input logic                  busy,
   input logic                  done,
   input logic [CNT_W-1:0]      cycle_count
);
   import lvl_seq_pkg::*;

   // R2
   preset_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uop == UOP_PRESET) |=> (uop == UOP_WR_DATA));

   // R2
   nor_a_then_nor_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uop == UOP_NOR_A) |=> (uop == UOP_NOR_B));

   // R3
   inv_preset_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uop == UOP_INV_PRESET) |=> (uop == UOP_INV_LOAD));

   // R3
   inv_load_then_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uop == UOP_INV_LOAD) |=> (uop == UOP_INV_EVAL));

   // R4
   slice_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((slice_en & (slice_en + 1'b1)) == '0));

   // R4
   slice_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((uop == UOP_IDLE) || (uop >= UOP_INV_PRESET)) |-> (slice_en == '0));

   // R5
   inv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uop == UOP_IDLE) |-> (inv_en == '0));

   // R6
   store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we != '0) |-> (uop == UOP_STORE));

   // R7
   level_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (buf_level >= $past(buf_level)));

   // R8
   done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy));

   // R8
   busy_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy == (uop != UOP_IDLE));

   // R9
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (cycle_count == $past(cycle_count) + 1'b1));

   // R10
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (cycle_count != '0));

endmodule

bind lvl_uop_sequencer lvl_seq_chk #(
   .NUM_SLICES (NUM_SLICES),
   .NUM_INV    (NUM_INV),
   .LVL_W      (LVL_W),
   .CNT_W      (CNT_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .uop         (uop),
   .slice_en    (slice_en),
   .inv_en      (inv_en),
   .buf_we      (buf_we),
   .buf_level   (buf_level),
   .busy        (busy),
   .done        (done),
   .cycle_count (cycle_count)
);

// File: tb/lvl_uop_sequencer_tb_top.sv
`timescale 1ns/1ps
module lvl_uop_sequencer_tb_top;

   localparam int NS  = 4;
   localparam int NI  = 4;
   localparam int ML  = 8;
   localparam int CW  = 16;
   localparam int LW  = 3;
   localparam int MW  = 3;
   localparam int IW  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tbl_we = 1'b0;
   logic [LW-1:0] tbl_level = '0;
   logic [MW-1:0] tbl_mux_cnt = '0;
   logic [IW-1:0] tbl_inv_cnt = '0;
   logic [LW:0]   level_count = '0;
   logic          start = 1'b0;
   logic [3:0]    uop;
   logic [NS-1:0] slice_en;
   logic [NI-1:0] inv_en;
   logic [NS-1:0] buf_we;
   logic [NI-1:0] buf_inv_we;
   logic [LW-1:0] buf_level;
   logic          busy;
   logic          done;
   logic [CW-1:0] cycle_count;

   int total = 0;
   int bad   = 0;

   int m_mux [ML];
   int m_inv [ML];

   int q_uop[$], q_sl[$], q_iv[$], q_bw[$], q_bi[$], q_lv[$];
   int exp_total;

   always #4 clk = ~clk;

   lvl_uop_sequencer #(
      .NUM_SLICES (NS),
      .NUM_INV    (NI),
      .MAX_LEVELS (ML),
      .CNT_W      (CW)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tbl_we      (tbl_we),
      .tbl_level   (tbl_level),
      .tbl_mux_cnt (tbl_mux_cnt),
      .tbl_inv_cnt (tbl_inv_cnt),
      .level_count (level_count),
      .start       (start),
      .uop         (uop),
      .slice_en    (slice_en),
      .inv_en      (inv_en),
      .buf_we      (buf_we),
      .buf_inv_we  (buf_inv_we),
      .buf_level   (buf_level),
      .busy        (busy),
      .done        (done),
      .cycle_count (cycle_count)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int therm(input int k, input int lanes);
      int n;
      n = (k > lanes) ? lanes : k;
      return (1 << n) - 1;
   endfunction

   task automatic wr(input int l, input int m, input int i);
      @(negedge clk);
      tbl_we      = 1'b1;
      tbl_level   = LW'(l);
      tbl_mux_cnt = MW'(m);
      tbl_inv_cnt = IW'(i);
      m_mux[l]    = m;
      m_inv[l]    = i;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic build(input int n);
      q_uop.delete(); q_sl.delete(); q_iv.delete();
      q_bw.delete();  q_bi.delete(); q_lv.delete();
      exp_total = 0;
      for (int l = 0; l < n && l < ML; l++) begin
         int mt, it;
         mt = therm(m_mux[l], NS);
         it = therm(m_inv[l], NI);
         if (m_mux[l] > 0) begin
            for (int s = 0; s < 8; s++) begin
               q_uop.push_back(1 + s);
               q_sl.push_back(mt);
               q_iv.push_back((s == 2) ? it : 0);
               q_bw.push_back((s == 7) ? mt : 0);
               q_bi.push_back((s == 7) ? it : 0);
               q_lv.push_back(l);
            end
            exp_total += 8;
         end else if (m_inv[l] > 0) begin
            for (int s = 0; s < 3; s++) begin
               q_uop.push_back(9 + s);
               q_sl.push_back(0);
               q_iv.push_back(it);
               q_bw.push_back(0);
               q_bi.push_back((s == 2) ? it : 0);
               q_lv.push_back(l);
            end
            exp_total += 3;
         end
      end
   endtask

   // Runs a case; inj >= 0 pulses start again at that step index (R10)
   task automatic run(input int n, input int inj);
      int k;
      build(n);
      @(negedge clk);
      level_count = (LW+1)'(n);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k = 0;
      while (q_uop.size() > 0) begin
         chk("R2/R3 uop", int'(uop), q_uop.pop_front());
         chk("R4 slice_en", int'(slice_en), q_sl.pop_front());
         chk("R5 inv_en", int'(inv_en), q_iv.pop_front());
         chk("R6 buf_we", int'(buf_we), q_bw.pop_front());
         chk("R6 buf_inv_we", int'(buf_inv_we), q_bi.pop_front());
         chk("R7 buf_level", int'(buf_level), q_lv.pop_front());
         chk("R8 busy", int'(busy), 1);
         chk("R8 done low", int'(done), 0);
         chk("R9 cycle_count", int'(cycle_count), k);
         if (k == inj) start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         k++;
      end
      chk("R8 done", int'(done), 1);
      chk("R8 busy low", int'(busy), 0);
      chk("R1 uop idle", int'(uop), 0);
      chk("R9 total", int'(cycle_count), exp_total);
      @(negedge clk);
      chk("R8 done held", int'(done), 1);
      chk("R10 count held", int'(cycle_count), exp_total);
   endtask

   initial begin
      #800000;
      bad++;
      total++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int l = 0; l < ML; l++) begin
         m_mux[l] = 0;
         m_inv[l] = 0;
      end
      repeat (3) @(negedge clk);
      chk("R1 uop", int'(uop), 0);
      chk("R1 slice_en", int'(slice_en), 0);
      chk("R1 inv_en", int'(inv_en), 0);
      chk("R1 buf_we", int'(buf_we), 0);
      chk("R1 buf_inv_we", int'(buf_inv_we), 0);
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 cycle_count", int'(cycle_count), 0);
      rst_n = 1'b1;

      // mixed, inverter-only and full-width levels back to back (R2..R7)
      wr(0, 3, 0);
      wr(1, 0, 2);
      wr(2, 2, 1);
      wr(3, 4, 3);
      run(4, -1);

      // empty levels skipped; stray start mid-run (R7, R10)
      wr(0, 0, 0);
      wr(1, 1, 4);
      wr(2, 0, 0);
      wr(3, 0, 1);
      wr(4, 0, 0);
      run(5, 4);
      run(5, 9);

      // no levels and all-empty levels (R8)
      run(0, -1);
      wr(1, 0, 0);
      wr(3, 0, 0);
      run(4, -1);

      // full table, then a shortened count (R7, R9)
      for (int l = 0; l < ML; l++) wr(l, l % 5, (l * 3) % 5);
      run(8, -1);
      run(2, 0);
      run(7, 3);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule